// File: doc/BRIEF.md
# Parallel Self-Synchronizing Scrambler

This block scrambles a data stream several bits per clock while producing exactly the same bit sequence as a one-bit-per-clock multiplicative scrambler. Each output bit is the input bit XORed with two earlier output bits, at distances set by the polynomial x^N + x^K + 1. The output bit at serial time t is therefore S(t) = D(t) ^ S(t-N) ^ S(t-(N-K)). Because the recursion feeds on scrambled bits, a receiver can descramble without any alignment to the sender's state.

A whole word of DATA_W bits is scrambled in one cycle. Bits late in the word depend on bits computed earlier in the same word, so the recursion is unrolled combinationally over the word. Only one register bank is kept: the last N scrambled bits. Two settings are used. The line-code setting is x^58 + x^19 + 1 over 64 bits, which is the default. The small setting is x^3 + x + 1 over 4 bits.

The output is registered, and its valid flag is aligned with the scrambled word. Words with the input valid flag low are ignored.

Top module: `scr_par`

## Requirements
- R1: While rst_ni is low, valid_o is 0 and data_o is 0, and the scrambler history is set to all ones. The first accepted word after reset is therefore scrambled against a history of N ones.
- R2: Within a word, bit 0 is earliest in serial time. Scrambled bit j equals data_i[j] ^ S(t-N) ^ S(t-(N-K)), where the history spans earlier bits of the same word and all previously accepted words, with no seam between words.
- R3: A word presented with valid_i high appears on data_o with valid_o high exactly one clock later. valid_o is low in the cycle after any cycle with valid_i low.
- R4: A cycle with valid_i low leaves the scrambler history unchanged, whatever data_i carries.
- R5: While valid_o is low, data_o keeps the last scrambled word. It stays 0 if no word has been accepted since reset.
- R6: With the default parameters (N=58, K=19, DATA_W=64), an all-zero first word after reset yields ones in bits 39 through 57 and zeros elsewhere.
- R7: With N=3, K=1 and DATA_W=4, an all-zero first word after reset yields 4'h4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid |
| data_i | input | DATA_W | Plain data word, bit 0 earliest |
| valid_o | output | 1 | Scrambled word valid |
| data_o | output | DATA_W | Scrambled word, bit 0 earliest |

## Verification
Every scrambled word and its valid flag are due exactly one rising edge after the edge that captured the input. The monitor samples 2 ns after each rising edge. At that point, valid_o must equal the valid_i value that the edge captured, which is still on the bus because inputs change only on falling edges. When valid_o is high, the word is compared with the next entry that a bit-serial reference pushed into the queue. When valid_o is low, the word must equal the one last seen.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // line-code setting: x^58 + x^19 + 1, 64 bits per clock
  localparam int unsigned LC_STATE_W   = 58;
  localparam int unsigned LC_MID_EXP   = 19;
  localparam int unsigned LC_DATA_W    = 64;
  // small setting: x^3 + x + 1, 4 bits per clock
  localparam int unsigned DEMO_STATE_W = 3;
  localparam int unsigned DEMO_MID_EXP = 1;
  localparam int unsigned DEMO_DATA_W  = 4;
endpackage

// File: rtl/scr_unroll.sv
module scr_unroll #(
  parameter int unsigned STATE_W = 58,
  parameter int unsigned MID_EXP = 19,
  parameter int unsigned DATA_W  = 64
) (
  input  logic [STATE_W-1:0] state_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic [DATA_W-1:0]  scr_o,
  output logic [STATE_W-1:0] next_state_o
);
  localparam int unsigned EXT_W = STATE_W + DATA_W;

  // ext[STATE_W-1:0] is history (index 0 oldest); above it, this word in serial order
  logic [EXT_W-1:0] ext;

  always_comb begin
    ext = '0;
    ext[STATE_W-1:0] = state_i;
    for (int j = 0; j < DATA_W; j++) begin
      ext[STATE_W+j] = data_i[j] ^ ext[j] ^ ext[j+MID_EXP];
    end
  end

  assign scr_o        = ext[EXT_W-1:STATE_W];
  assign next_state_o = ext[EXT_W-1:DATA_W];
endmodule

// File: rtl/scr_state_reg.sv
module scr_state_reg #(
  parameter int unsigned STATE_W = 58
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_o <= '1;
    else if (load_i) state_o <= next_i;
  end
endmodule

// File: rtl/scr_out_reg.sv
module scr_out_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) data_o <= data_i;
    end
  end
endmodule

// File: rtl/scr_par.sv
module scr_par
  import scr_pkg::*;
#(
  parameter int unsigned STATE_W = LC_STATE_W,
  parameter int unsigned MID_EXP = LC_MID_EXP,
  parameter int unsigned DATA_W  = LC_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  logic [STATE_W-1:0] state_q;
  logic [STATE_W-1:0] state_d;
  logic [DATA_W-1:0]  scr_d;

  scr_unroll #(
    .STATE_W(STATE_W), .MID_EXP(MID_EXP), .DATA_W(DATA_W)
  ) u_unroll (
    .state_i     (state_q),
    .data_i      (data_i),
    .scr_o       (scr_d),
    .next_state_o(state_d)
  );

  scr_state_reg #(.STATE_W(STATE_W)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (valid_i),
    .next_i (state_d),
    .state_o(state_q)
  );

  scr_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .data_i (scr_d),
    .valid_o(valid_o),
    .data_o (data_o)
  );

  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r3_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r4_idle_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(state_q));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // newest history bit is the last bit sent
  a_r2_state_tail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> state_q[STATE_W-1] == data_o[DATA_W-1]);
endmodule

// File: tb/sim_scr_par.sv
module sim_scr_par;
  import scr_pkg::*;
  localparam int W0 = LC_DATA_W,   N0 = LC_STATE_W,   K0 = LC_MID_EXP;
  localparam int W1 = DEMO_DATA_W, N1 = DEMO_STATE_W, K1 = DEMO_MID_EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v0 = 1'b0, v1 = 1'b0;
  logic [W0-1:0] d0 = '0;
  logic [W1-1:0] d1 = '0;
  logic vo0, vo1;
  logic [W0-1:0] do0;
  logic [W1-1:0] do1;

  int checks = 0, errors = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;

  // reference history: index 0 = most recent scrambled bit
  logic [N0-1:0] h0 = '1;
  logic [N1-1:0] h1 = '1;
  logic [W0-1:0] q0[$];
  logic [W1-1:0] q1[$];
  string t0[$], t1[$];
  logic [W0-1:0] last0 = '0;
  logic [W1-1:0] last1 = '0;

  always #4 clk = ~clk;

  scr_par u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v0), .data_i(d0),
    .valid_o(vo0), .data_o(do0)
  );

  scr_par #(.STATE_W(N1), .MID_EXP(K1), .DATA_W(W1)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(v1), .data_i(d1),
    .valid_o(vo1), .data_o(do1)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // drive one cycle on both instances; bit-serial reference builds the expected word
  task automatic drive(input bit en0, input logic [W0-1:0] x0,
                       input bit en1, input logic [W1-1:0] x1, input string tag);
    logic [W0-1:0] e0;
    logic [W1-1:0] e1;
    logic s;
    @(negedge clk);
    v0 = en0; d0 = x0; v1 = en1; d1 = x1;
    if (en0) begin
      for (int j = 0; j < W0; j++) begin
        s = x0[j] ^ h0[N0-1] ^ h0[N0-K0-1];
        e0[j] = s;
        h0 = {h0[N0-2:0], s};
      end
      q0.push_back(e0);
      t0.push_back({tag, " (64b)"});
    end
    if (en1) begin
      for (int j = 0; j < W1; j++) begin
        s = x1[j] ^ h1[N1-1] ^ h1[N1-K1-1];
        e1[j] = s;
        h1 = {h1[N1-2:0], s};
      end
      q1.push_back(e1);
      t1.push_back({tag, " (4b)"});
    end
  endtask

  // monitor: 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (mon_en) begin
        check(vo0 == v0, "R3 valid timing (64b)", 64'(vo0), 64'(v0));
        if (vo0) begin
          if (q0.size() == 0) check(1'b0, "R3 unexpected word (64b)", do0, 64'(0));
          else begin
            logic [W0-1:0] e;
            string tg;
            e = q0.pop_front();
            tg = t0.pop_front();
            check(do0 == e, tg, do0, e);
          end
          last0 = do0;
        end else check(do0 == last0, "R5 hold (64b)", do0, last0);

        check(vo1 == v1, "R3 valid timing (4b)", 64'(vo1), 64'(v1));
        if (vo1) begin
          if (q1.size() == 0) check(1'b0, "R3 unexpected word (4b)", 64'(do1), 64'(0));
          else begin
            logic [W1-1:0] e;
            string tg;
            e = q1.pop_front();
            tg = t1.pop_front();
            check(do1 == e, tg, 64'(do1), 64'(e));
          end
          last1 = do1;
        end else check(do1 == last1, "R5 hold (4b)", 64'(do1), 64'(last1));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_sim();
  end

  initial begin
    #20;
    check(vo0 == 1'b0 && do0 == '0, "R1 reset outputs (64b)", do0, 64'(0));
    check(vo1 == 1'b0 && do1 == '0, "R1 reset outputs (4b)", 64'(do1), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;

    // R1 seed, R6 and R7 hand-computed first words
    drive(1'b1, '0, 1'b1, '0, "R1 seed word");
    @(posedge clk);
    #3;
    check(do0 == (64'h7FFFF << 39), "R6 first zero word", do0, 64'h7FFFF << 39);
    check(do1 == 4'h4, "R7 first zero word", 64'(do1), 64'h4);

    for (int i = 0; i < 40; i++)
      drive(1'b1, {$urandom, $urandom}, 1'b1, 4'($urandom), "R2 continuous random");

    // idle cycles carry junk data that must be ignored
    for (int i = 0; i < 60; i++) begin
      bit g0 = 1'($urandom);
      bit g1 = 1'($urandom);
      drive(g0, {$urandom, $urandom}, g1, 4'($urandom), "R4 stream with gaps");
    end

    for (int i = 0; i < 10; i++)
      drive(1'b1, '1, 1'b1, '1, "R2 all ones");

    for (int k = 0; k < W0; k++)
      drive(1'b1, W0'(1) << k, 1'b1, W1'(1) << (k % W1), "R2 walking one");

    for (int i = 0; i < 4; i++)
      drive(1'b0, {$urandom, $urandom}, 1'b0, 4'($urandom), "");
    @(posedge clk);
    #3;
    check(q0.size() == 0, "R3 all words delivered (64b)", 64'(q0.size()), 64'(0));
    check(q1.size() == 0, "R3 all words delivered (4b)", 64'(q1.size()), 64'(0));
    finish_sim();
  end
endmodule